// File: doc/BRIEF.md
# Double-Buffered DAC Register Model

This block models the digital front end of a 12-bit digital-to-analog converter as seen from the device side. It has two stages. A staging register captures a parallel data word while chip select and the write strobe are both low. An output register then drives the converter code. The output register copies the staging register while an active-low load strobe is held low. A word can therefore be staged without disturbing the code being converted, and applied later with a separate load pulse.

When chip select, write and load are all low at once, a bus word passes through both stages and reaches the output code in a single cycle. Every control input is sampled on the block clock. A cycle-counting monitor on chip select and on the load strobe raises a one-cycle flag when either strobe was held low for fewer cycles than a configured minimum. This lets the model act as a checking target for a controller that drives the interface.

Top module: `dac_dbuf_model`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets both the staging code and the output code to mid-scale 12'h800 and clears both violation flags.
- R2: On a clock edge where cs_n=0 and wr_n=0, stage_code takes the value of din. While that condition holds, stage_code keeps following din cycle after cycle.
- R3: On a clock edge where cs_n=1, din has no effect. stage_code is unchanged, and dac_code is unchanged unless ld_n=0.
- R4: On a clock edge where cs_n=0 and wr_n=1, din is ignored and stage_code is unchanged.
- R5: On a clock edge where ld_n=0, dac_code takes the value that stage_code holds after that same edge. The output register is transparent for as long as ld_n stays low.
- R6: On a clock edge where cs_n, wr_n and ld_n are all 0, dac_code takes din directly (write-through).
- R7: On a clock edge where ld_n=1, dac_code is unchanged.
- R8: If cs_n was low for between 1 and MIN_LOW-1 consecutive sampled cycles and is then sampled high, cs_short is 1 for exactly the following cycle. A low run of MIN_LOW cycles or more raises no flag. The default MIN_LOW is 4.
- R9: The same rule as R8 applies to ld_n, reported on ld_short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low (high means read/no write) |
| ld_n | input | 1 | Load strobe for the output register, active low |
| din | input | 12 | Parallel data bus |
| stage_code | output | 12 | Contents of the staging register |
| dac_code | output | 12 | Contents of the output register; stands in for the analog level |
| cs_short | output | 1 | One-cycle flag: chip-select low pulse was too short |
| ld_short | output | 1 | One-cycle flag: load low pulse was too short |

## Verification
The assertions assume that every control input and the data bus are synchronous to clk and settle between edges. They also assume that the load strobe is a plain level and is never combined with chip select. The bench changes inputs only on the falling clock edge and holds them through the next rising edge, so each edge sees one clean set of values. Pulse widths are shaped in whole clock periods, which makes a run of exactly MIN_LOW cycles the boundary that the flag checks use.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic ld_n;
  } bus_ctl_t;

  function automatic logic [31:0] mid_scale(input int unsigned width);
    return 32'd1 << (width - 1);
  endfunction

endpackage

// File: rtl/dac_stage_reg.sv
module dac_stage_reg
  import dac_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_ctl_t          ctl,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] q_next
);

  localparam logic [DATA_W-1:0] RESET_CODE = DATA_W'(mid_scale(DATA_W));

  logic wr_en;

  assign wr_en  = ~ctl.cs_n & ~ctl.wr_n;
  assign q_next = wr_en ? din : q;

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_CODE;
    else     q <= q_next;
  end

  // R2
  stage_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.cs_n && !ctl.wr_n) |=> (q == $past(din)));

  // R3 R4
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.cs_n || ctl.wr_n) |=> $stable(q));

endmodule

// File: rtl/dac_out_reg.sv
module dac_out_reg #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_n,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] code
);

  localparam logic [DATA_W-1:0] RESET_CODE = DATA_W'(dac_dbuf_pkg::mid_scale(DATA_W));

  always_ff @(posedge clk) begin
    if (rst)        code <= RESET_CODE;
    else if (!ld_n) code <= src;
  end

  // R5
  out_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> (code == $past(src)));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ld_n |=> $stable(code));

endmodule

// File: rtl/dac_pulse_mon.sv
module dac_pulse_mon #(
  parameter int unsigned MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic short_flag
);

  localparam int unsigned CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

  logic [CNT_W-1:0] low_cnt;
  logic             too_short;

  assign too_short = strobe_n && (low_cnt != '0) && (low_cnt < CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt    <= '0;
      short_flag <= 1'b0;
    end else begin
      short_flag <= too_short;
      if (strobe_n)                low_cnt <= '0;
      else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
    end
  end

  // R8 R9
  flag_single_chk: assert property (@(posedge clk) disable iff (rst)
    short_flag |=> !short_flag);

  // R8 R9
  flag_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(short_flag) |-> $past(strobe_n));

endmodule

// File: rtl/dac_dbuf_model.sv
module dac_dbuf_model
  import dac_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned MIN_LOW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] stage_code,
  output logic [DATA_W-1:0] dac_code,
  output logic              cs_short,
  output logic              ld_short
);

  localparam int unsigned N_MON = 2;

  bus_ctl_t          ctl;
  logic [DATA_W-1:0] stage_next;
  logic [N_MON-1:0]  mon_in;
  logic [N_MON-1:0]  mon_flag;

  assign ctl    = '{cs_n: cs_n, wr_n: wr_n, ld_n: ld_n};
  assign mon_in = {ld_n, cs_n};

  dac_stage_reg #(.DATA_W(DATA_W)) i_stage (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .din    (din),
    .q      (stage_code),
    .q_next (stage_next)
  );

  dac_out_reg #(.DATA_W(DATA_W)) i_out (
    .clk  (clk),
    .rst  (rst),
    .ld_n (ld_n),
    .src  (stage_next),
    .code (dac_code)
  );

  for (genvar g = 0; g < N_MON; g++) begin : g_mon
    dac_pulse_mon #(.MIN_LOW(MIN_LOW)) i_mon (
      .clk        (clk),
      .rst        (rst),
      .strobe_n   (mon_in[g]),
      .short_flag (mon_flag[g])
    );
  end

  assign cs_short = mon_flag[0];
  assign ld_short = mon_flag[1];

  // R6
  write_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && !ld_n) |=> (dac_code == $past(din)));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dac_code == 12'h800 && stage_code == 12'h800 && !cs_short && !ld_short));

endmodule

// File: tb/test_dac_dbuf_model.sv
module test_dac_dbuf_model;

  localparam int DW = 12;
  localparam int NV = 14;
  // fields: req[3:0] cs wr ld din exp_stage exp_dac
  localparam int VW = 4 + 3 + 3 * DW;

  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd3, 3'b111, 12'h123, 12'h800, 12'h800}, // R3 idle bus ignored
    {4'd2, 3'b001, 12'h123, 12'h123, 12'h800}, // R2 stage write
    {4'd2, 3'b001, 12'h456, 12'h456, 12'h800}, // R2 stage follows bus
    {4'd3, 3'b101, 12'h777, 12'h456, 12'h800}, // R3 cs high
    {4'd4, 3'b011, 12'h999, 12'h456, 12'h800}, // R4 read cycle
    {4'd5, 3'b110, 12'h999, 12'h456, 12'h456}, // R5 load
    {4'd7, 3'b111, 12'haaa, 12'h456, 12'h456}, // R7 hold
    {4'd6, 3'b000, 12'h0ff, 12'h0ff, 12'h0ff}, // R6 write-through
    {4'd6, 3'b000, 12'hfff, 12'hfff, 12'hfff}, // R6
    {4'd6, 3'b000, 12'h000, 12'h000, 12'h000}, // R6
    {4'd3, 3'b110, 12'h321, 12'h000, 12'h000}, // R3 with load low
    {4'd2, 3'b001, 12'habc, 12'habc, 12'h000}, // R2
    {4'd7, 3'b111, 12'h000, 12'habc, 12'h000}, // R7
    {4'd5, 3'b110, 12'h000, 12'habc, 12'habc}  // R5
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] stage_code, dac_code;
  logic          cs_short, ld_short;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dac_dbuf_model i_dac_dbuf_model (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n), .din(din),
    .stage_code(stage_code), .dac_code(dac_code),
    .cs_short(cs_short), .ld_short(ld_short)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
    step();
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 stage", stage_code, 12'h800);
    chk("R1 dac", dac_code, 12'h800);
    chk("R1 cs_short", cs_short, 0);
    chk("R1 ld_short", ld_short, 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      {cs_n, wr_n, ld_n} = v[3*DW +: 3];
      din = v[2*DW +: DW];
      step();
      chk($sformatf("R%0d vec%0d stage", v[VW-1 -: 4], i), stage_code, v[DW +: DW]);
      chk($sformatf("R%0d vec%0d dac", v[VW-1 -: 4], i), dac_code, v[0 +: DW]);
    end

    // R1 reset from non-mid-scale state
    do_reset();
    chk("R1 re-reset stage", stage_code, 12'h800);
    chk("R1 re-reset dac", dac_code, 12'h800);

    // R8 short chip-select pulse (2 cycles)
    cs_n = 1'b0; wr_n = 1'b1;
    step(); step();
    cs_n = 1'b1;
    step();
    chk("R8 short cs flag", cs_short, 1);
    step();
    chk("R8 flag one cycle", cs_short, 0);

    // R8 boundary: exactly MIN_LOW (4) cycles, no flag
    cs_n = 1'b0;
    for (int k = 0; k < 4; k++) step();
    cs_n = 1'b1;
    step();
    chk("R8 min width no flag", cs_short, 0);
    step();
    chk("R8 min width no flag later", cs_short, 0);

    // R9 short load pulse (3 cycles)
    ld_n = 1'b0;
    for (int k = 0; k < 3; k++) step();
    ld_n = 1'b1;
    step();
    chk("R9 short ld flag", ld_short, 1);
    chk("R9 cs flag untouched", cs_short, 0);
    step();
    chk("R9 flag one cycle", ld_short, 0);

    // R9 long load pulse (6 cycles), no flag
    ld_n = 1'b0;
    for (int k = 0; k < 6; k++) step();
    ld_n = 1'b1;
    step();
    chk("R9 long ld no flag", ld_short, 0);

    done = 1'b1;
    summary();
  end

endmodule